// File: doc/BRIEF.md
# Select-Synchronized SPI Slave Port

This block is the receiving end of a four-wire serial link. An external master drives the serial clock and, optionally, an active-low select line. The port exchanges one byte per transfer, most significant bit first. It shifts in the master's data while it shifts out a byte that local logic loaded earlier. All pin inputs are brought into the system clock domain through two-stage synchronizers. Serial clock edges are then found by comparing consecutive synchronized samples. Clock polarity and the edge bit together select one of the four standard SPI timing modes.

A received byte moves to a single receive buffer. That raises a buffer-full indication and an interrupt flag. If a byte completes while the buffer is still unread, the new byte is dropped and a sticky overflow flag is raised. If local logic writes a new transmit byte while a transfer is under way, the write is rejected and a sticky collision flag is raised. A mode code selects whether the select line gates the port. When it does, a high select floats the data output at once and throws away any partial byte.

Top module: `spi_slave_port`

## Requirements
- R1: The port runs only when `enable` is 1 and `mode_sel` is 4'b0100 (select-gated) or 4'b0101 (select ignored). With any other code, or with `enable` at 0, `sdo_oe` is 0 and no byte is received.
- R2: In select-gated mode, `sdo_oe` follows the inverse of `ssel_n` with no clock delay. A high select floats the output even in the middle of a byte.
- R3: In select-gated mode, a high select, or a port that is not running, returns the bit counter to zero. A partial byte is discarded, and the next transfer starts at its first bit. A write to the transmit register is then accepted without raising the collision flag.
- R4: Serial data is taken most significant bit first. When the eighth bit is sampled into an empty buffer, `rd_data` shows the byte and both `buf_full` and `irq_flag` become 1.
- R5: When a byte completes while `buf_full` is 1, the byte is dropped, `rd_data` keeps the earlier byte, and `ovf_flag` becomes 1. It stays 1 until `flag_clr[1]` is pulsed.
- R6: A `wr_en` pulse while a transfer is in progress is ignored, so the byte being sent is unchanged. It sets `col_flag`, which stays 1 until `flag_clr[2]` is pulsed.
- R7: A `rd_en` pulse clears `buf_full`. `flag_clr[0]` clears `irq_flag`, `flag_clr[1]` clears `ovf_flag` and `flag_clr[2]` clears `col_flag`.
- R8: `cpol` sets the idle level of the serial clock. With `cke` at 1, data is sampled on the idle-to-active transition and changed on the active-to-idle transition. With `cke` at 0, it is the reverse. (SPI mode 0 = cpol 0/cke 1, mode 1 = 0/0, mode 2 = 1/1, mode 3 = 1/0.)
- R9: With `cke` at 1, the most significant transmit bit is on `sdo` as soon as the byte is written or select falls, before any clock edge.
- R10: In mode 4'b0101 the select line is ignored: `sdo_oe` is 1 and transfers run with `ssel_n` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; at 0 the port is held idle |
| mode_sel | input | 4 | 4'b0100 select-gated, 4'b0101 select ignored |
| cpol | input | 1 | Idle level of the serial clock |
| cke | input | 1 | Edge bit: 1 = output changes on the active-to-idle transition |
| sck | input | 1 | Serial clock from the master |
| ssel_n | input | 1 | Active-low select from the master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| wr_en | input | 1 | Load transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Acknowledge the receive buffer |
| rd_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| col_flag | output | 1 | Sticky write collision flag |
| irq_flag | output | 1 | Byte-received interrupt flag |
| flag_clr | input | 3 | Clear pulses: [0] irq, [1] overflow, [2] collision |

## Verification
The embedded checks assume that the serial clock stays high and low for at least three system clocks each, so that every transition is seen once after synchronization. They also assume that serial data is steady across the sampling transition, and that select does not change within a couple of clocks of a serial clock edge. The bench acts as the master with six-clock half periods. It changes all pin inputs only on the falling system edge, and it waits several clocks after each select change before it toggles the clock. Collision and overflow cases are produced on purpose, by writing in the middle of a byte and by sending a byte without acknowledging the one before it.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam logic [3:0] MODE_SEL_GATED = 4'b0100;
  localparam logic [3:0] MODE_SEL_FREE  = 4'b0101;

  typedef struct packed {
    logic sample;
    logic shift;
  } sck_event_t;

  // Idle-to-active and active-to-idle, given the idle level.
  function automatic logic leading_edge(input logic pol, input logic rise, input logic fall);
    return pol ? fall : rise;
  endfunction

  function automatic logic trailing_edge(input logic pol, input logic rise, input logic fall);
    return pol ? rise : fall;
  endfunction

  // Edge bit 1: sample on leading, shift on trailing; edge bit 0: swapped.
  function automatic sck_event_t classify_edge(input logic pol, input logic edge_bit,
                                               input logic rise, input logic fall);
    sck_event_t ev;
    logic lead, trail;
    lead      = leading_edge(pol, rise, fall);
    trail     = trailing_edge(pol, rise, fall);
    ev.sample = edge_bit ? lead : trail;
    ev.shift  = edge_bit ? trail : lead;
    return ev;
  endfunction

  function automatic logic mode_is_valid(input logic [3:0] code);
    return (code == MODE_SEL_GATED) || (code == MODE_SEL_FREE);
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_slv_shifter.sv
module spi_slv_shifter
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cke,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              ss_fall,
  input  logic              wr_accept,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sdo_bit,
  output logic              busy,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic             sck_d;
  logic             sck_rise, sck_fall;
  sck_event_t       ev;
  logic             do_sample, do_shift;
  logic [CNT_W-1:0] bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic             sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign sck_rise  = sck_s & ~sck_d;
  assign sck_fall  = ~sck_s & sck_d;
  assign ev        = classify_edge(cpol, cke, sck_rise, sck_fall);
  assign do_sample = run & ev.sample;
  assign do_shift  = run & ev.shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              bit_cnt <= '0;
    else if (!run)           bit_cnt <= '0;
    else if (do_sample)      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shreg <= '0;
    else if (wr_accept)  shreg <= wr_data;
    else if (do_sample)  shreg <= {shreg[DATA_W-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sdo_q <= 1'b0;
    else if (wr_accept)                  sdo_q <= wr_data[DATA_W-1];
    else if (do_shift)                   sdo_q <= shreg[DATA_W-1];
    else if (run && cke && ss_fall)      sdo_q <= shreg[DATA_W-1];
  end

  assign sdo_bit   = sdo_q;
  assign busy      = (bit_cnt != '0);
  assign byte_done = do_sample && (bit_cnt == LAST);
  assign rx_byte   = {shreg[DATA_W-2:0], sdi_s};

  // R3
  cnt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (bit_cnt == '0));

  // R6
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !do_sample) |=> $stable(shreg));

endmodule

// File: rtl/spi_slv_flags.sv
module spi_slv_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rd_en,
  input  logic              wr_collide,
  input  logic [2:0]        clr,
  output logic [DATA_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              ovf,
  output logic              col,
  output logic              irq
);

  logic load_buf;
  logic drop_byte;

  assign load_buf  = byte_done & ~buf_full;
  assign drop_byte = byte_done & buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_buf <= '0;
    else if (load_buf) rx_buf <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        buf_full <= 1'b0;
    else if (load_buf) buf_full <= 1'b1;
    else if (rd_en)    buf_full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (drop_byte) ovf <= 1'b1;
    else if (clr[1])    ovf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          col <= 1'b0;
    else if (wr_collide) col <= 1'b1;
    else if (clr[2])     col <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (load_buf) irq <= 1'b1;
    else if (clr[0])   irq <= 1'b0;
  end

  // R4
  byte_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !buf_full) |=> (buf_full && irq && rx_buf == $past(rx_byte)));

  // R5
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && buf_full) |=> (ovf && $stable(rx_buf)));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr[1]) |=> ovf);

  // R6
  collision_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |=> col);

  // R7
  read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !byte_done) |=> !buf_full);

endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [3:0]        mode_sel,
  input  logic              cpol,
  input  logic              cke,
  input  logic              sck,
  input  logic              ssel_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              ovf_flag,
  output logic              col_flag,
  output logic              irq_flag,
  input  logic [2:0]        flag_clr
);

  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b010;  // select idles high

  logic [PIN_N-1:0] pins_s;
  logic sck_s, ss_s, sdi_s, ss_d;
  logic port_on, gated, sel_ok, run, ss_fall;
  logic busy, wr_accept, wr_collide, byte_done, sdo_bit;
  logic [DATA_W-1:0] rx_byte;

  spi_slv_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sck, ssel_n, sdi}),
    .q_out (pins_s)
  );

  assign {sck_s, ss_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_d <= 1'b1;
    else        ss_d <= ss_s;
  end

  assign port_on    = enable & mode_is_valid(mode_sel);
  assign gated      = (mode_sel == MODE_SEL_GATED);
  assign sel_ok     = gated ? ~ss_s : 1'b1;
  assign run        = port_on & sel_ok;
  assign ss_fall    = gated & ss_d & ~ss_s;
  assign wr_accept  = wr_en & ~busy;
  assign wr_collide = wr_en & busy;

  spi_slv_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cpol      (cpol),
    .cke       (cke),
    .sck_s     (sck_s),
    .sdi_s     (sdi_s),
    .ss_fall   (ss_fall),
    .wr_accept (wr_accept),
    .wr_data   (wr_data),
    .sdo_bit   (sdo_bit),
    .busy      (busy),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  spi_slv_flags #(.DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .rd_en      (rd_en),
    .wr_collide (wr_collide),
    .clr        (flag_clr),
    .rx_buf     (rd_data),
    .buf_full   (buf_full),
    .ovf        (ovf_flag),
    .col        (col_flag),
    .irq        (irq_flag)
  );

  assign sdo    = sdo_bit;
  assign sdo_oe = port_on & (gated ? ~ssel_n : 1'b1);

  // R1
  idle_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_on |-> !byte_done);

endmodule

// File: tb/tb_spi_slave_port.sv
module tb_spi_slave_port;

  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [3:0] mode_sel = 4'b0100;
  logic cpol = 1'b0, cke = 1'b1;
  logic sck = 1'b0, ssel_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic buf_full, ovf_flag, col_flag, irq_flag;
  logic [2:0] flag_clr = '0;

  int checks = 0;
  int fails = 0;
  logic [7:0] miso_acc;

  always #4 clk = ~clk;

  spi_slave_port dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_sel(mode_sel),
    .cpol(cpol), .cke(cke), .sck(sck), .ssel_n(ssel_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .buf_full(buf_full),
    .ovf_flag(ovf_flag), .col_flag(col_flag), .irq_flag(irq_flag),
    .flag_clr(flag_clr)
  );

  // {cpol, cke, slave tx byte, master byte}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b1, 8'hA5, 8'h3C},
    {1'b0, 1'b0, 8'h81, 8'h7E},
    {1'b1, 1'b1, 8'h0F, 8'hF0},
    {1'b1, 1'b0, 8'hC3, 8'h55},
    {1'b0, 1'b1, 8'h00, 8'hFF},
    {1'b1, 1'b0, 8'hFF, 8'h00}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_buf();
    @(negedge clk); rd_en = 1'b1; flag_clr = 3'b001;
    @(negedge clk); rd_en = 1'b0; flag_clr = 3'b000;
  endtask

  // Master side: bits first..last of a byte, collecting sdo into miso_acc.
  task automatic run_bits(input logic [7:0] mosi, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      if (cke) begin
        sdi = mosi[7-i];
        wait_clk(H);
        miso_acc[7-i] = sdo;
        sck = ~cpol;
        wait_clk(H);
        sck = cpol;
      end else begin
        sck = ~cpol;
        sdi = mosi[7-i];
        wait_clk(H);
        miso_acc[7-i] = sdo;
        sck = cpol;
        wait_clk(H);
      end
    end
    wait_clk(H);
  endtask

  task automatic set_mode(input logic p, input logic e);
    @(negedge clk); cpol = p; cke = e; sck = p;
    wait_clk(4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // Reset state, port disabled
    check(buf_full == 0 && irq_flag == 0, "R4 reset buf_full/irq", {buf_full, irq_flag}, 0);
    check(ovf_flag == 0 && col_flag == 0, "R5 reset ovf/col", {ovf_flag, col_flag}, 0);
    check(sdo_oe == 0, "R1 reset sdo_oe", sdo_oe, 0);

    enable = 1'b1;
    mode_sel = 4'b0100;

    // Table walk over the four timing modes (R8, R9, R4, R7)
    foreach (VEC[k]) begin
      set_mode(VEC[k][17], VEC[k][16]);
      write_tx(VEC[k][15:8]);
      if (cke) begin
        check(sdo == VEC[k][15], "R9 first bit after write", sdo, VEC[k][15]);
      end
      ssel_n = 1'b0;
      wait_clk(4);
      run_bits(VEC[k][7:0], 0, 7);
      check(rd_data == VEC[k][7:0], "R8 received byte", rd_data, VEC[k][7:0]);
      check(miso_acc == VEC[k][15:8], "R8 R9 transmitted byte", miso_acc, VEC[k][15:8]);
      check(buf_full && irq_flag, "R4 full and irq", {buf_full, irq_flag}, 2'b11);
      read_buf();
      check(!buf_full && !irq_flag, "R7 read and clear", {buf_full, irq_flag}, 0);
      ssel_n = 1'b1;
      wait_clk(4);
    end

    // R2 and R3: abort in the middle of a byte
    set_mode(1'b0, 1'b1);
    write_tx(8'h12);
    ssel_n = 1'b0;
    wait_clk(4);
    run_bits(8'hFF, 0, 2);
    @(negedge clk); ssel_n = 1'b1;
    #1;
    check(sdo_oe == 0, "R2 sdo floats at once", sdo_oe, 0);
    wait_clk(5);
    check(buf_full == 0, "R3 no byte from partial", buf_full, 0);
    write_tx(8'h34);
    wait_clk(2);
    check(col_flag == 0, "R3 counter cleared, write accepted", col_flag, 0);
    ssel_n = 1'b0;
    wait_clk(4);
    check(sdo_oe == 1, "R2 sdo driven when selected", sdo_oe, 1);
    run_bits(8'h5A, 0, 7);
    check(rd_data == 8'h5A, "R3 realigned rx", rd_data, 8'h5A);
    check(miso_acc == 8'h34, "R3 realigned tx", miso_acc, 8'h34);
    read_buf();

    // R6 collision
    ssel_n = 1'b1;
    wait_clk(4);
    write_tx(8'hC7);
    ssel_n = 1'b0;
    wait_clk(4);
    run_bits(8'h11, 0, 3);
    write_tx(8'hFF);
    wait_clk(1);
    check(col_flag == 1, "R6 collision flag", col_flag, 1);
    run_bits(8'h11, 4, 7);
    check(miso_acc == 8'hC7, "R6 write ignored", miso_acc, 8'hC7);
    check(rd_data == 8'h11, "R6 rx unaffected", rd_data, 8'h11);
    wait_clk(10);
    check(col_flag == 1, "R6 collision sticky", col_flag, 1);
    @(negedge clk); flag_clr = 3'b100;
    @(negedge clk); flag_clr = 3'b000;
    check(col_flag == 0, "R7 collision clear", col_flag, 0);
    read_buf();

    // R5 overflow
    write_tx(8'hAA);
    run_bits(8'h21, 0, 7);
    write_tx(8'hBB);
    run_bits(8'h42, 0, 7);
    check(ovf_flag == 1, "R5 overflow set", ovf_flag, 1);
    check(rd_data == 8'h21, "R5 old byte kept", rd_data, 8'h21);
    wait_clk(20);
    check(ovf_flag == 1, "R5 overflow sticky", ovf_flag, 1);
    @(negedge clk); flag_clr = 3'b010;
    @(negedge clk); flag_clr = 3'b000;
    check(ovf_flag == 0, "R7 overflow clear", ovf_flag, 0);
    read_buf();
    ssel_n = 1'b1;
    wait_clk(4);

    // R10 select ignored
    mode_sel = 4'b0101;
    set_mode(1'b0, 1'b0);
    check(sdo_oe == 1, "R10 driven without select", sdo_oe, 1);
    write_tx(8'h96);
    run_bits(8'h69, 0, 7);
    check(rd_data == 8'h69, "R10 rx without select", rd_data, 8'h69);
    check(miso_acc == 8'h96, "R10 tx without select", miso_acc, 8'h96);
    read_buf();

    // R1 invalid mode code
    mode_sel = 4'b0011;
    ssel_n = 1'b0;
    wait_clk(4);
    check(sdo_oe == 0, "R1 invalid code floats", sdo_oe, 0);
    run_bits(8'hE7, 0, 7);
    check(buf_full == 0, "R1 invalid code no rx", buf_full, 0);

    // R1 enable low
    mode_sel = 4'b0100;
    enable = 1'b0;
    wait_clk(4);
    check(sdo_oe == 0, "R1 disabled floats", sdo_oe, 0);
    run_bits(8'h3E, 0, 7);
    check(buf_full == 0, "R1 disabled no rx", buf_full, 0);

    finish_run();
  end

endmodule